// File: doc/BRIEF.md
# Multi-Mode Bitmap Pixel Serializer

The block turns video bytes read from display memory into one pen index per pixel slot. A pixel-clock enable paces it. Every byte fills eight enable slots in all modes. The display mode decides how many pixels share one byte, and so how long each pixel lasts and how many bits form its pen.

The serializer asks memory for two consecutive bytes per character clock. Its phase output drives the lowest memory address bit, so the even byte is fetched first and the odd byte second. It loads each byte into one shift register at the exact slot where the previous byte's last pixel is shown. A sixteen-entry writable palette then turns each pen into a colour code. While display enable is low, the output carries the border pen.

Top module: `pix_serializer`

## Requirements
- R1: After reset, `vld_o` and `phase_o` are 0 and `pen_o` equals `border_i`.
- R2: In two-colour mode (`mode_i` = 2 or 3), a byte gives eight one-slot pixels, MSB first. The pen is {000, bit}.
- R3: In four-colour mode (`mode_i` = 1), pixel p (0..3) lasts two slots. Its pen bit 0 is byte bit 7-p and pen bit 1 is byte bit 3-p. So 11110000 gives pen 1, 00001111 gives pen 2 and 11111111 gives pen 3.
- R4: In sixteen-colour mode (`mode_i` = 0), pixel p (0..1) lasts four slots. Its pen bits 0, 1, 2 and 3 come from byte bits 7-p, 3-p, 5-p and 1-p.
- R5: Each displayed byte occupies exactly eight valid slots. `ld_o` is high together with `vld_o` only in the eighth slot of a byte.
- R6: `phase_o` is 0 for the first load after display enable rises and toggles on every load. The odd byte's first pixel must decode from the odd byte itself, never from the leftover shifted bits of the even byte.
- R7: `mode_i` is sampled only at a load. A change while a byte is shown does not alter that byte's decoding.
- R8: While `disp_en_i` is low, `pen_o` equals `border_i`, and `vld_o` and `ld_o` stay low.
- R9: `colour_o` equals palette entry `pen_o`. A write through `pal_we_i`/`pal_addr_i`/`pal_data_i` takes effect in the next cycle. Entry i resets to i.
- R10: In a cycle with `pix_en_i` low, `ld_o` and `vld_o` are low and the slot position and `phase_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-slot enable |
| disp_en_i | input | 1 | Display enable |
| mode_i | input | 2 | 0 sixteen-colour, 1 four-colour, 2/3 two-colour |
| border_i | input | 4 | Pen shown outside the display area |
| data_i | input | 8 | Video byte from memory at address bit 0 = `phase_o` |
| ld_o | output | 1 | Byte on `data_i` is loaded at this edge |
| phase_o | output | 1 | Character-clock phase, lowest memory address bit |
| pen_o | output | 4 | Pen index for the current slot |
| vld_o | output | 1 | Current slot is a displayed pixel |
| colour_o | output | COL_W | Palette colour for `pen_o` |
| pal_we_i | input | 1 | Palette write enable |
| pal_addr_i | input | 4 | Palette entry to write |
| pal_data_i | input | COL_W | Palette write data |

## Verification
The critical overlap is a byte load landing in the same enable as the final slot of the previous byte. That slot's pen must still come from the old byte while the new byte, and a possibly new mode, are captured at the same edge. The bench provokes this continuously: it streams bytes back to back, changes `mode_i` right after every load, and uses a gapped enable pattern. At each slot that carries `ld_o` it judges the pen against the old byte's layout, and it checks the following slot against the new byte. For four-colour odd bytes it also checks that the pen differs from the one a skipped load would produce.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SLOT_N = 8;
  localparam int unsigned CNT_W  = $clog2(SLOT_N);
  localparam int unsigned PEN_W  = 4;

  typedef enum logic [1:0] {
    MODE_PEN16 = 2'd0,
    MODE_PEN4  = 2'd1,
    MODE_PEN2  = 2'd2,
    MODE_PEN2X = 2'd3
  } pix_mode_e;

  // fixed tap positions; the register moves one bit per pixel
  function automatic logic [PEN_W-1:0] pen_pick(logic [BYTE_W-1:0] sr, pix_mode_e m);
    case (m)
      MODE_PEN16: pen_pick = {sr[1], sr[5], sr[3], sr[7]};
      MODE_PEN4:  pen_pick = {2'b00, sr[3], sr[7]};
      default:    pen_pick = {3'b000, sr[7]};
    endcase
  endfunction

  // slot index after which the next pixel begins
  function automatic logic step_due(logic [CNT_W-1:0] cnt, pix_mode_e m);
    case (m)
      MODE_PEN16: step_due = (cnt[1:0] == 2'b11);
      MODE_PEN4:  step_due = cnt[0];
      default:    step_due = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pix_ser_seq.sv
module pix_ser_seq
  import pix_ser_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pix_en_i,
  input  logic      disp_en_i,
  input  logic [1:0] mode_i,
  output logic      load_o,
  output logic      shift_o,
  output logic      act_o,
  output logic      phase_o,
  output pix_mode_e mode_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q, phase_q;
  pix_mode_e        mode_q;

  localparam logic [CNT_W-1:0] LastSlot = CNT_W'(SLOT_N - 1);

  assign load_o  = pix_en_i & disp_en_i & (~act_q | (cnt_q == LastSlot));
  assign shift_o = pix_en_i & disp_en_i & act_q & ~load_o & step_due(cnt_q, mode_q);
  assign act_o   = act_q;
  assign phase_o = phase_q;
  assign mode_o  = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      act_q   <= 1'b0;
      phase_q <= 1'b0;
      mode_q  <= MODE_PEN16;
    end else if (pix_en_i) begin
      if (!disp_en_i) begin
        cnt_q   <= '0;
        act_q   <= 1'b0;
        phase_q <= 1'b0;
      end else if (load_o) begin
        cnt_q   <= '0;
        act_q   <= 1'b1;
        phase_q <= ~phase_q;
        mode_q  <= pix_mode_e'(mode_i);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pix_ser_shreg.sv
module pix_ser_shreg
  import pix_ser_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  pix_mode_e         mode_i,
  output logic [PEN_W-1:0]  pen_o
);
  logic [BYTE_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= byte_i;
    else if (shift_i) sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
  end

  assign pen_o = pen_pick(sr_q, mode_i);
endmodule

// File: rtl/pix_ser_palette.sv
module pix_ser_palette #(
  parameter int unsigned PEN_W = 4,
  parameter int unsigned COL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PEN_W-1:0] waddr_i,
  input  logic [COL_W-1:0] wdata_i,
  input  logic [PEN_W-1:0] pen_i,
  output logic [COL_W-1:0] colour_o
);
  localparam int unsigned Depth = 1 << PEN_W;

  logic [COL_W-1:0] ent_q [Depth];

  for (genvar g = 0; g < Depth; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ent_q[g] <= COL_W'(g);
      else if (we_i && (waddr_i == PEN_W'(g)))        ent_q[g] <= wdata_i;
    end
  end

  assign colour_o = ent_q[pen_i];
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
  import pix_ser_pkg::*;
#(
  parameter int unsigned COL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  input  logic             disp_en_i,
  input  logic [1:0]       mode_i,
  input  logic [3:0]       border_i,
  input  logic [7:0]       data_i,
  output logic             ld_o,
  output logic             phase_o,
  output logic [3:0]       pen_o,
  output logic             vld_o,
  output logic [COL_W-1:0] colour_o,
  input  logic             pal_we_i,
  input  logic [3:0]       pal_addr_i,
  input  logic [COL_W-1:0] pal_data_i
);
  logic             load, shift, act;
  pix_mode_e        mode_q;
  logic [PEN_W-1:0] sr_pen;

  pix_ser_seq u_seq (
    .clk_i, .rst_ni, .pix_en_i, .disp_en_i, .mode_i,
    .load_o(load), .shift_o(shift), .act_o(act), .phase_o, .mode_o(mode_q)
  );

  pix_ser_shreg u_shreg (
    .clk_i, .rst_ni, .load_i(load), .shift_i(shift),
    .byte_i(data_i), .mode_i(mode_q), .pen_o(sr_pen)
  );

  assign ld_o  = load;
  assign vld_o = pix_en_i & disp_en_i & act;
  assign pen_o = (act && disp_en_i) ? sr_pen : border_i;

  pix_ser_palette #(.PEN_W(PEN_W), .COL_W(COL_W)) u_pal (
    .clk_i, .rst_ni, .we_i(pal_we_i), .waddr_i(pal_addr_i),
    .wdata_i(pal_data_i), .pen_i(pen_o), .colour_o
  );
endmodule

// File: rtl/pix_serializer_chk.sv
module pix_serializer_chk #(
  parameter int unsigned COL_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_en_i,
  input logic             disp_en_i,
  input logic [3:0]       border_i,
  input logic             ld_o,
  input logic             vld_o,
  input logic             phase_o,
  input logic [3:0]       pen_o,
  input logic [COL_W-1:0] colour_o,
  input logic             pal_we_i,
  input logic [3:0]       pal_addr_i,
  input logic [COL_W-1:0] pal_data_i
);
  logic [2:0] slots_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  slots_q <= '0;
    else if (!disp_en_i || ld_o)  slots_q <= '0;
    else if (vld_o)               slots_q <= slots_q + 1'b1;
  end

  // R8
  border_when_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_en_i |-> (!ld_o && !vld_o && pen_o == border_i));

  // R6
  phase_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |=> (phase_o != $past(phase_o)));

  // R5
  load_at_last_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_o && vld_o) |-> (slots_q == 3'd7));

  // R5
  no_early_ninth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !ld_o) |-> (slots_q != 3'd7));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |-> (!ld_o && !vld_o));

  // R10
  idle_phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(phase_o));

  // R9
  pal_write_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_we_i |=> (pen_o != $past(pal_addr_i) || colour_o == $past(pal_data_i)));
endmodule

bind pix_serializer pix_serializer_chk #(.COL_W(COL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_en_i(pix_en_i), .disp_en_i(disp_en_i),
  .border_i(border_i), .ld_o(ld_o), .vld_o(vld_o), .phase_o(phase_o),
  .pen_o(pen_o), .colour_o(colour_o), .pal_we_i(pal_we_i),
  .pal_addr_i(pal_addr_i), .pal_data_i(pal_data_i)
);

// File: tb/pix_serializer_test.sv
module pix_serializer_test;
  localparam int COL_W = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             pix_en;
  logic             disp_en = 1'b0;
  logic [1:0]       mode;
  logic [3:0]       border = 4'd9;
  logic [7:0]       data;
  logic             ld, phase, vld;
  logic [3:0]       pen;
  logic [COL_W-1:0] colour;
  logic             pal_we = 1'b0;
  logic [3:0]       pal_addr = '0;
  logic [COL_W-1:0] pal_data = '0;

  logic [7:0] bytes [16];
  logic [1:0] modes [16];
  logic [COL_W-1:0] pal_m [16];
  int ld_idx = 0;
  int vcount = 0;
  logic clr_idx = 1'b1;
  int checks = 0, errors = 0, cyc = 0;
  logic [1:0] en_div = '0;
  logic done = 1'b0;

  assign pix_en = (en_div != 2'd2);
  assign data   = bytes[ld_idx[3:0]];
  assign mode   = modes[ld_idx[3:0]];

  pix_serializer #(.COL_W(COL_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .disp_en_i(disp_en),
    .mode_i(mode), .border_i(border), .data_i(data), .ld_o(ld),
    .phase_o(phase), .pen_o(pen), .vld_o(vld), .colour_o(colour),
    .pal_we_i(pal_we), .pal_addr_i(pal_addr), .pal_data_i(pal_data)
  );

  function automatic logic [3:0] exp_pen(input logic [7:0] b, input logic [1:0] m, input int slot);
    int p;
    if (m == 2'd0) begin
      p = slot / 4;
      return {b[1-p], b[5-p], b[3-p], b[7-p]};
    end else if (m == 2'd1) begin
      p = slot / 2;
      return {2'b00, b[3-p], b[7-p]};
    end
    p = slot;
    return {3'b000, b[7-p]};
  endfunction

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    en_div <= (en_div == 2'd2) ? 2'd0 : en_div + 2'd1;
    if (clr_idx) ld_idx <= 0;
    else if (ld) ld_idx <= ld_idx + 1;
    cyc <= cyc + 1;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL R5 watchdog: cycles %0d expected below %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (clr_idx) vcount = 0;
      if (!disp_en) begin
        // R8
        chk("R8 border", pen == border && !vld && !ld, {vld, ld, pen}, {2'b00, border});
      end
      if (!pix_en) begin
        // R10
        chk("R10 idle slot", !vld && !ld, {vld, ld}, 0);
      end
      if (ld) begin
        // R6 phase selects even then odd byte
        chk("R6 phase", phase == ld_idx[0], phase, ld_idx[0]);
      end
      if (vld) begin
        automatic int b = vcount / 8;
        automatic int s = vcount % 8;
        automatic logic [3:0] e = exp_pen(bytes[b[3:0]], modes[b[3:0]], s);
        // R2 R3 R4 R7 decode under the mode latched for this byte
        chk("R2/R3/R4/R7 pen", pen == e, pen, e);
        // R9
        chk("R9 colour", colour == pal_m[e], colour, pal_m[e]);
        // R5 load only on the eighth slot
        chk("R5 load slot", ld == (s == 7), ld, s == 7);
        if (modes[b[3:0]] == 2'd1 && b[0] && s == 0) begin
          automatic logic [3:0] fp = exp_pen(8'(bytes[b[3:0]-4'd1] << 4), 2'd1, 0);
          if (fp != e) chk("R6 odd byte not leftover", pen != fp, pen, e);
        end
        vcount = vcount + 1;
      end
    end
  end

  task automatic run(input int n);
    @(posedge clk); #1;
    disp_en = 1'b0;
    clr_idx = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    clr_idx = 1'b0;
    disp_en = 1'b1;
    while (vcount < n * 8 && cyc < 150000) @(posedge clk);
    #1;
    disp_en = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic pal_wr(input logic [3:0] a, input logic [COL_W-1:0] d);
    @(posedge clk); #1;
    pal_we = 1'b1; pal_addr = a; pal_data = d;
    @(posedge clk);
    pal_m[a] = d;
    #1;
    pal_we = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      pal_m[i] = COL_W'(i);
      bytes[i] = '0;
      modes[i] = 2'd2;
    end
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset vld", vld == 1'b0, vld, 0);
    chk("R1 reset phase", phase == 1'b0, phase, 0);
    chk("R1 reset pen", pen == border, pen, border);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R2 two-colour patterns
    bytes[0] = 8'hA5; bytes[1] = 8'h3C; bytes[2] = 8'h00; bytes[3] = 8'hFF;
    bytes[4] = 8'h81; bytes[5] = 8'h7E; bytes[6] = 8'h0F; bytes[7] = 8'hF0;
    run(8);

    // R3 four-colour, includes pen 1/2/3 examples and leftover contrast (R6)
    for (int i = 0; i < 16; i++) modes[i] = 2'd1;
    bytes[0] = 8'hF0; bytes[1] = 8'h0F; bytes[2] = 8'hFF; bytes[3] = 8'hF0;
    bytes[4] = 8'h0F; bytes[5] = 8'hFF; bytes[6] = 8'h5A; bytes[7] = 8'hC3;
    run(8);

    // R4 sixteen-colour
    for (int i = 0; i < 16; i++) modes[i] = 2'd0;
    bytes[0] = 8'h0C; bytes[1] = 8'h30; bytes[2] = 8'hCF; bytes[3] = 8'hAA;
    bytes[4] = 8'h55; bytes[5] = 8'h12; bytes[6] = 8'h84; bytes[7] = 8'hE1;
    run(8);

    // R9 palette writes, then R7 per-byte mode changes
    pal_wr(4'd1, 5'd30);
    pal_wr(4'd6, 5'd17);
    pal_wr(4'd0, 5'd21);
    for (int i = 0; i < 16; i++) begin
      modes[i] = 2'((i * 3 + 1) % 4);
      bytes[i] = 8'((i * 37 + 11) % 256);
    end
    run(16);

    // exhaustive byte sweep in every mode
    for (int m = 0; m < 3; m++) begin
      for (int blk = 0; blk < 16; blk++) begin
        for (int i = 0; i < 16; i++) begin
          bytes[i] = 8'(blk * 16 + i);
          modes[i] = 2'(m);
        end
        run(16);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule